// File: doc/BRIEF.md
# Charger settings word-register serial slave

This block is the serial control port of a battery-charger controller. It watches an open-drain two-wire bus (SMBus/I2C signalling) through its clock and data pins, and answers a bus master that uses the Read-Word and Write-Word protocols. It never starts a transfer. Its job is to hold three charger settings: charge current, charge voltage and input current. It drives these settings straight to the charger control logic and also returns them, along with two fixed identity words, when the master reads.

Both pins are brought into the system-clock domain through a short synchronizer. All bus events come from comparing consecutive synchronized samples: clock edges, START and STOP. A transfer begins with a control byte, which is the 7-bit device address and a direction bit. A register-address byte follows. A write then carries two data bytes, least significant byte first. A read instead issues a repeated START and the read control byte, and the block then returns the two data bytes, low byte first. The data output is an active-high "pull low" enable for an external open-drain pad.

Top module: `chg_smbus_slave`

## Requirements
- R1: Only control byte 0x12 (address 0x09, direction bit 0 = write) or 0x13 (direction bit 1 = read) is acknowledged. Any other control byte gets no acknowledge, and the block leaves the bus alone until the next START.
- R2: After an addressed control byte, after the register-address byte and after each write data byte, the block pulls SDA low for the whole ninth clock.
- R3: A word goes low byte first in both directions. Within a byte the MSB goes first. In a read, the master acknowledges the low byte and the block then sends the high byte.
- R4: The writable words keep only their setting field; every other bit reads as 0. The fields are: 0x14 charge current in bits [12:7], 0x15 charge voltage in bits [14:4], 0x3F input current in bits [12:7]. The fields drive `ichg_set`, `vchg_set` and `iin_set`.
- R5: After reset the words read 0x14 = 0x0000, 0x15 = 0x0000, 0x3F = 0x0080, 0xFE = 0x0049 and 0xFF = 0x0001.
- R6: Writes to 0xFE, 0xFF or any unmapped address are acknowledged and then discarded. A read of an unmapped address returns 0x0000.
- R7: A word is updated only once its high data byte has been acknowledged. A transfer cut off by STOP before that point leaves every setting unchanged.
- R8: A START at any point restarts control-byte reception, and a STOP at any point returns the block to idle. A new transfer after an interrupted one works normally.
- R9: The block changes its data drive only while SCL is low, and it never drives SDA while idle.
- R10: When the master does not acknowledge the high read byte, the block releases SDA and goes idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock pin level |
| sda_i | input | 1 | Bus data pin level, as seen on the wire |
| sda_oe | output | 1 | 1 = pull the data line low |
| ichg_set | output | 6 | Charge current setting field |
| vchg_set | output | 11 | Charge voltage setting field |
| iin_set | output | 6 | Input current setting field |

## Verification
The assertions assume a well-behaved master. It changes SDA only while SCL is low, except when it makes START and STOP. It holds each SCL level for many system clocks, so that the three-cycle synchronizer delay ends well inside each phase. It never signals START or STOP while the slave is pulling the line low. The bench master keeps to these rules by construction: every bus phase lasts ten system clocks, data changes one phase after each SCL fall, and START and STOP are issued only after the slave has let go of the line.

// File: rtl/chg_smb_pkg.sv
package chg_smb_pkg;

  localparam int WORD_W   = 16;
  localparam int NUM_WREG = 3;

  localparam logic [7:0] RA_ICHG = 8'h14;
  localparam logic [7:0] RA_VCHG = 8'h15;
  localparam logic [7:0] RA_IIN  = 8'h3F;
  localparam logic [7:0] RA_MFG  = 8'hFE;
  localparam logic [7:0] RA_DEV  = 8'hFF;

  localparam logic [WORD_W-1:0] ID_MFG = 16'h0049;
  localparam logic [WORD_W-1:0] ID_DEV = 16'h0001;

  localparam int ICHG_LSB = 7;
  localparam int ICHG_W   = 6;
  localparam int VCHG_LSB = 4;
  localparam int VCHG_W   = 11;
  localparam int IIN_LSB  = 7;
  localparam int IIN_W    = 6;

  typedef enum logic [2:0] {S_IDLE, S_RX, S_SACK, S_TX, S_MACK} bus_st_e;
  typedef enum logic [1:0] {PH_CTRL, PH_REG, PH_LO, PH_HI} phase_e;

  // index of a writable word -> its bus address
  function automatic logic [7:0] wr_addr(input int idx);
    case (idx)
      0:       return RA_ICHG;
      1:       return RA_VCHG;
      default: return RA_IIN;
    endcase
  endfunction

  // bits a write may change at a given address
  function automatic logic [WORD_W-1:0] field_mask(input logic [7:0] ra);
    logic [WORD_W-1:0] m;
    m = '0;
    case (ra)
      RA_ICHG: m[ICHG_LSB +: ICHG_W] = '1;
      RA_VCHG: m[VCHG_LSB +: VCHG_W] = '1;
      RA_IIN:  m[IIN_LSB  +: IIN_W]  = '1;
      default: m = '0;
    endcase
    return m;
  endfunction

  function automatic logic [WORD_W-1:0] reset_word(input logic [7:0] ra);
    return (ra == RA_IIN) ? 16'h0080 : 16'h0000;
  endfunction

endpackage

// File: rtl/chg_smb_sync.sv
module chg_smb_sync #(
  parameter int STAGES = 2,
  parameter int W      = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '1;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/chg_smb_regs.sv
module chg_smb_regs
  import chg_smb_pkg::*;
#(
  parameter int NW = NUM_WREG
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [7:0]        wa,
  input  logic [WORD_W-1:0] wd,
  input  logic [7:0]        ra,
  output logic [WORD_W-1:0] rd,
  output logic [ICHG_W-1:0] ichg_set,
  output logic [VCHG_W-1:0] vchg_set,
  output logic [IIN_W-1:0]  iin_set
);
  logic [WORD_W-1:0] mem [NW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NW; i++) mem[i] <= reset_word(wr_addr(i));
    end else if (we) begin
      for (int i = 0; i < NW; i++)
        if (wa == wr_addr(i)) mem[i] <= wd & field_mask(wr_addr(i));
    end
  end

  always_comb begin
    rd = '0;
    if (ra == RA_MFG) rd = ID_MFG;
    else if (ra == RA_DEV) rd = ID_DEV;
    for (int i = 0; i < NW; i++)
      if (ra == wr_addr(i)) rd = mem[i];
  end

  assign ichg_set = mem[0][ICHG_LSB +: ICHG_W];
  assign vchg_set = mem[1][VCHG_LSB +: VCHG_W];
  assign iin_set  = mem[2][IIN_LSB  +: IIN_W];
endmodule

// File: rtl/chg_smbus_slave.sv
module chg_smbus_slave
  import chg_smb_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h09,
  parameter int         SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_oe,
  output logic [5:0]  ichg_set,
  output logic [10:0] vchg_set,
  output logic [5:0]  iin_set
);
  localparam int BW = 8;
  localparam int CW = $clog2(BW + 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(BW);
  localparam logic [CW-1:0] CNT_LAST = CW'(BW - 1);

  // pin sampling and bus events
  logic [1:0] pins_s;
  logic       scl_s, sda_s, scl_d, sda_d;

  chg_smb_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({scl_i, sda_i}),
    .q     (pins_s)
  );

  assign scl_s = pins_s[1];
  assign sda_s = pins_s[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  logic scl_rise, scl_fall, start_evt, stop_evt;
  assign scl_rise  =  scl_s & ~scl_d;
  assign scl_fall  = ~scl_s &  scl_d;
  assign start_evt =  scl_s &  scl_d &  sda_d & ~sda_s;
  assign stop_evt  =  scl_s &  scl_d & ~sda_d &  sda_s;

  // protocol state
  bus_st_e        st;
  phase_e         ph;
  logic [CW-1:0]  bitcnt;
  logic [BW-1:0]  shreg;
  logic [BW-1:0]  reg_addr;
  logic [BW-1:0]  lo_q;
  logic           rw_q, tx_hi, mack_ok;
  logic [WORD_W-1:0] rd_word;

  // named events for the checker
  logic st_idle, rx_fresh, wr_commit;
  assign st_idle   = (st == S_IDLE);
  assign rx_fresh  = (st == S_RX) && (ph == PH_CTRL) && (bitcnt == '0);
  assign wr_commit = (st == S_SACK) && (ph == PH_HI) && scl_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      ph       <= PH_CTRL;
      bitcnt   <= '0;
      shreg    <= '0;
      reg_addr <= '0;
      lo_q     <= '0;
      rw_q     <= 1'b0;
      tx_hi    <= 1'b0;
      mack_ok  <= 1'b0;
    end else if (start_evt) begin
      st     <= S_RX;
      ph     <= PH_CTRL;
      bitcnt <= '0;
    end else if (stop_evt) begin
      st <= S_IDLE;
    end else begin
      case (st)
        S_RX: begin
          if (scl_rise && bitcnt != CNT_FULL) begin
            shreg  <= {shreg[BW-2:0], sda_s};
            bitcnt <= bitcnt + 1'b1;
          end else if (scl_fall && bitcnt == CNT_FULL) begin
            bitcnt <= '0;
            case (ph)
              PH_CTRL: begin
                if (shreg[BW-1:1] == DEV_ADDR) begin
                  rw_q <= shreg[0];
                  st   <= S_SACK;
                end else begin
                  st <= S_IDLE;
                end
              end
              PH_REG: begin
                reg_addr <= shreg;
                st       <= S_SACK;
              end
              PH_LO: begin
                lo_q <= shreg;
                st   <= S_SACK;
              end
              default: st <= S_SACK;
            endcase
          end
        end
        S_SACK: begin
          if (scl_fall) begin
            case (ph)
              PH_CTRL: begin
                if (rw_q) begin
                  st    <= S_TX;
                  shreg <= rd_word[7:0];
                  tx_hi <= 1'b0;
                end else begin
                  st <= S_RX;
                  ph <= PH_REG;
                end
              end
              PH_REG: begin
                st <= S_RX;
                ph <= PH_LO;
              end
              PH_LO: begin
                st <= S_RX;
                ph <= PH_HI;
              end
              default: st <= S_IDLE;
            endcase
          end
        end
        S_TX: begin
          if (scl_fall) begin
            if (bitcnt == CNT_LAST) begin
              st     <= S_MACK;
              bitcnt <= '0;
            end else begin
              shreg  <= {shreg[BW-2:0], 1'b0};
              bitcnt <= bitcnt + 1'b1;
            end
          end
        end
        S_MACK: begin
          if (scl_rise) begin
            mack_ok <= ~sda_s;
          end else if (scl_fall) begin
            if (mack_ok && !tx_hi) begin
              st    <= S_TX;
              shreg <= rd_word[15:8];
              tx_hi <= 1'b1;
            end else begin
              st <= S_IDLE;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign sda_oe = (st == S_SACK) || ((st == S_TX) && !shreg[BW-1]);

  chg_smb_regs #(.NW(NUM_WREG)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (wr_commit),
    .wa       (reg_addr),
    .wd       ({shreg, lo_q}),
    .ra       (reg_addr),
    .rd       (rd_word),
    .ichg_set (ichg_set),
    .vchg_set (vchg_set),
    .iin_set  (iin_set)
  );
endmodule

// File: rtl/chg_smb_chk.sv
module chg_smb_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        scl_s,
  input logic        start_evt,
  input logic        stop_evt,
  input logic        st_idle,
  input logic        rx_fresh,
  input logic        wr_commit,
  input logic        sda_oe,
  input logic [5:0]  ichg_set,
  input logic [10:0] vchg_set,
  input logic [5:0]  iin_set
);
  // R9: drive changes only with the synchronized clock low
  p_oe_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_s);

  // R1 / R9: nothing driven while idle
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    st_idle |-> !sda_oe);

  // R8: START rearms control-byte reception
  p_start_rearm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> rx_fresh);

  // R8: STOP returns to idle
  p_stop_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> st_idle);

  // R7: settings move only on a committed write
  p_commit_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_commit |=> ($stable(ichg_set) && $stable(vchg_set) && $stable(iin_set)));
endmodule

bind chg_smbus_slave chg_smb_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_s     (scl_s),
  .start_evt (start_evt),
  .stop_evt  (stop_evt),
  .st_idle   (st_idle),
  .rx_fresh  (rx_fresh),
  .wr_commit (wr_commit),
  .sda_oe    (sda_oe),
  .ichg_set  (ichg_set),
  .vchg_set  (vchg_set),
  .iin_set   (iin_set)
);

// File: tb/tb_chg_smbus_slave.sv
module tb_chg_smbus_slave;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_oe;
  logic [5:0]  ichg_set;
  logic [10:0] vchg_set;
  logic [5:0]  iin_set;
  wire sda_line = m_sda & ~sda_oe;

  int n_chk = 0;
  int n_bad = 0;
  int oe_bad = 0;
  logic prev_oe = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  chg_smbus_slave dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (m_scl),
    .sda_i    (sda_line),
    .sda_oe   (sda_oe),
    .ichg_set (ichg_set),
    .vchg_set (vchg_set),
    .iin_set  (iin_set)
  );

  // R9 monitor: drive may only move while the bus clock is low
  always @(negedge clk) begin
    if (rst_n && m_scl && (sda_oe !== prev_oe)) oe_bad++;
    prev_oe = sda_oe;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic ph();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; ph();
    m_scl = 1'b1; ph();
    m_sda = 1'b0; ph();
    m_scl = 1'b0; ph();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; ph();
    m_scl = 1'b1; ph();
    m_sda = 1'b1; ph();
  endtask

  task automatic put_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; ph();
      m_scl = 1'b1; ph(); ph();
      m_scl = 1'b0; ph();
    end
    m_sda = 1'b1; ph();
    m_scl = 1'b1; ph();
    acked = (sda_line == 1'b0);
    ph();
    m_scl = 1'b0; ph();
  endtask

  task automatic get_byte(input bit give_ack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      ph();
      m_scl = 1'b1; ph();
      b[i] = sda_line;
      ph();
      m_scl = 1'b0; ph();
    end
    m_sda = give_ack ? 1'b0 : 1'b1; ph();
    m_scl = 1'b1; ph(); ph();
    m_scl = 1'b0; ph();
    m_sda = 1'b1;
  endtask

  task automatic wr_word(input logic [7:0] ra, input logic [15:0] d, output bit all_ack);
    bit a0, a1, a2, a3;
    bus_start();
    put_byte(8'h12, a0);
    put_byte(ra, a1);
    put_byte(d[7:0], a2);
    put_byte(d[15:8], a3);
    bus_stop();
    all_ack = a0 & a1 & a2 & a3;
  endtask

  task automatic rd_word(input logic [7:0] ra, output logic [15:0] v, output bit all_ack);
    bit a0, a1, a2;
    logic [7:0] lo, hi;
    bus_start();
    put_byte(8'h12, a0);
    put_byte(ra, a1);
    bus_start();
    put_byte(8'h13, a2);
    get_byte(1'b1, lo);
    get_byte(1'b0, hi);
    bus_stop();
    v = {hi, lo};
    all_ack = a0 & a1 & a2;
  endtask

  // independent view of what a word keeps after a write
  function automatic logic [15:0] kept(input logic [7:0] ra, input logic [15:0] d);
    case (ra)
      8'h14, 8'h3F: return {3'b000, d[12:7], 7'b0000000};
      8'h15:        return {1'b0, d[14:4], 4'b0000};
      default:      return 16'h0000;
    endcase
  endfunction

  task automatic t_reset();
    logic [15:0] v;
    bit ok;
    check(sda_oe == 1'b0, "R9 idle after reset", sda_oe, 0);
    check(ichg_set == 6'd0, "R5 ichg reset", ichg_set, 0);
    check(vchg_set == 11'd0, "R5 vchg reset", vchg_set, 0);
    check(iin_set == 6'd1, "R5 iin reset", iin_set, 1);
    rd_word(8'h3F, v, ok);
    check(ok, "R2 read acks", ok, 1);
    check(v == 16'h0080, "R5 word 0x3F", v, 16'h0080);
    rd_word(8'h15, v, ok);
    check(v == 16'h0000, "R5 word 0x15", v, 0);
    rd_word(8'hFE, v, ok);
    check(v == 16'h0049, "R5 word 0xFE", v, 16'h0049);
    rd_word(8'hFF, v, ok);
    check(v == 16'h0001, "R5 word 0xFF", v, 16'h0001);
    check(sda_oe == 1'b0, "R10 released after read", sda_oe, 0);
  endtask

  task automatic t_fields();
    logic [15:0] v;
    bit ok;
    wr_word(8'h14, 16'hFFFF, ok);
    check(ok, "R2 write acks", ok, 1);
    check(ichg_set == 6'h3F, "R4 ichg field", ichg_set, 6'h3F);
    rd_word(8'h14, v, ok);
    check(v == kept(8'h14, 16'hFFFF), "R4 0x14 readback", v, kept(8'h14, 16'hFFFF));
    wr_word(8'h15, 16'h1234, ok);
    check(vchg_set == 11'h123, "R4 vchg field", vchg_set, 11'h123);
    rd_word(8'h15, v, ok);
    check(v == kept(8'h15, 16'h1234), "R4 0x15 readback", v, kept(8'h15, 16'h1234));
    wr_word(8'h3F, 16'h0F80, ok);
    check(iin_set == 6'h1F, "R3 low byte first on write", iin_set, 6'h1F);
    rd_word(8'h3F, v, ok);
    check(v == 16'h0F80, "R3 low byte first on read", v, 16'h0F80);
  endtask

  task automatic t_bad_addr();
    bit a0, a1;
    logic [15:0] v;
    bit ok;
    bus_start();
    put_byte(8'h20, a0);
    put_byte(8'h14, a1);
    bus_stop();
    check(!a0, "R1 foreign address NACK", a0, 0);
    check(!a1, "R1 no ack after foreign address", a1, 0);
    bus_start();
    put_byte(8'h13 ^ 8'h80, a0);
    bus_stop();
    check(!a0, "R1 near-miss address NACK", a0, 0);
    rd_word(8'h14, v, ok);
    check(v == 16'h1F80, "R1 settings untouched", v, 16'h1F80);
  endtask

  task automatic t_readonly();
    logic [15:0] v;
    bit ok;
    wr_word(8'hFE, 16'h1234, ok);
    check(ok, "R6 read-only write acked", ok, 1);
    rd_word(8'hFE, v, ok);
    check(v == 16'h0049, "R6 id kept", v, 16'h0049);
    wr_word(8'h30, 16'hFFFF, ok);
    check(ok, "R6 unmapped write acked", ok, 1);
    rd_word(8'h30, v, ok);
    check(v == 16'h0000, "R6 unmapped read zero", v, 0);
    check(ichg_set == 6'h3F && vchg_set == 11'h123 && iin_set == 6'h1F,
          "R6 settings untouched", {ichg_set, vchg_set, iin_set}, {6'h3F, 11'h123, 6'h1F});
  endtask

  task automatic t_trunc();
    bit a;
    bus_start();
    put_byte(8'h12, a);
    put_byte(8'h14, a);
    put_byte(8'h00, a);
    bus_stop();
    check(ichg_set == 6'h3F, "R7 stop after low byte", ichg_set, 6'h3F);
    bus_start();
    put_byte(8'h12, a);
    put_byte(8'h15, a);
    put_byte(8'h00, a);
    bus_start();
    put_byte(8'h12, a);
    check(a, "R8 restart mid-write acks", a, 1);
    put_byte(8'h14, a);
    put_byte(8'h00, a);
    put_byte(8'h05, a);
    bus_stop();
    check(vchg_set == 11'h123, "R8 interrupted word kept", vchg_set, 11'h123);
    check(ichg_set == 6'h0A, "R8 write after restart", ichg_set, 6'h0A);
    check(sda_oe == 1'b0, "R8 idle after stop", sda_oe, 0);
  endtask

  initial begin
    repeat (150000) @(negedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_fields();
    t_bad_addr();
    t_readonly();
    t_trunc();
    check(oe_bad == 0, "R9 drive moved with SCL high", oe_bad, 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule